// File: doc/BRIEF.md
# MSI Vector Capture Controller

This block turns inbound memory-write messages into message-signalled interrupt vectors. A write whose 64-bit target address equals the programmed message address is taken as an interrupt message. Its 32-bit data word is read as a global vector number, and the matching pending bit is set in a bank of 32-bit interrupt groups.

Software programs the block through a simple 32-bit register port. It sets the message address, and for each group it sets an enable word and a mask word. It reads the pending (status) word and clears bits by writing ones. Pending bits that are not masked are combined into one level-sensitive interrupt output. Vector allocation and any mapping to an operating-system interrupt number are left to software.

Top module: `msi_vec_ctrl`

## Requirements
- R1: After reset, every register reads zero: message address low and high words, and each group's enable, mask and status. `irq_o` is low.
- R2: The message address low word is read and written at byte offset 0x820. The high word is at 0x824. A write is visible on `reg_rdata_o` in the cycle after the write edge. Offsets with no register read as zero.
- R3: Group g has its enable word at 0x828 + 12·g, its mask word at 0x82C + 12·g and its status word at 0x830 + 12·g. Enable and mask are plain read/write.
- R4: A message is valid when `msg_valid_i` is high and `msg_addr_i` equals {high word, low word}. A valid message with data n sets status bit n%32 of group n/32, provided enable bit n%32 of that group is set. The bit reads back in the cycle after the message edge.
- R5: A vector whose enable bit is clear is never latched into status. Clearing an enable bit leaves an already-latched status bit in place.
- R6: A message whose address differs from the programmed address in either word changes no status bit.
- R7: A message whose data is 32·NUM_GROUPS or higher is dropped and changes no status bit.
- R8: A write to a status word clears each bit written as 1. Each bit written as 0 is unchanged. Writes to enable or mask words do not change status.
- R9: If a status clear and a valid message hit the same bit in one cycle, the bit stays set. Other bits in the same clear still clear.
- R10: `irq_o` is high when any status bit has its mask bit clear. It follows status and mask one cycle later, because it is registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from `reg_addr_i` |
| msg_valid_i | input | 1 | Inbound memory write present |
| msg_addr_i | input | 64 | Inbound write target address |
| msg_data_i | input | 32 | Inbound write data, the global vector number |
| irq_o | output | 1 | Combined interrupt, level |

## Verification
A register write or message issued on one rising edge shows in `reg_rdata_o` right after that edge. `irq_o` follows one edge later. The bench drives every stimulus on a falling edge and lets one rising edge pass before it samples any register. It lets a second rising edge pass before it samples `irq_o`, and it always samples on falling edges. Read data is combinational, so each read settles for a short delay after the address is applied and before it is sampled.

The bench sweeps every vector of a two-group build, one at a time. For each vector it checks the status bit, the interrupt, and the clear on the cycle each is due. It then covers:
- sparse enable patterns;
- masks;
- address mismatch in either word;
- out-of-range vectors;
- a clear and a message hitting the same bit in one cycle.

// File: rtl/msi_pkg.sv
package msi_pkg;
  localparam int REG_AW = 12;
  localparam int GRP_W  = 32;
  localparam logic [REG_AW-1:0] ADDR_LO_OFF = 12'h820;
  localparam logic [REG_AW-1:0] ADDR_HI_OFF = 12'h824;
  localparam int GRP_BASE   = 'h828;
  localparam int GRP_STRIDE = 12;

  typedef enum int {REG_ENA = 0, REG_MASK = 1, REG_STAT = 2} grp_reg_e;

  function automatic logic [REG_AW-1:0] grp_reg_off(int g, grp_reg_e k);
    return REG_AW'(GRP_BASE + g * GRP_STRIDE + int'(k) * 4);
  endfunction
endpackage

// File: rtl/msi_addr_regs.sv
module msi_addr_regs
  import msi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic [63:0]       msg_addr_i,
  output logic [31:0]       lo_o,
  output logic [31:0]       hi_o,
  output logic              match_o
);
  logic [31:0] lo_q, hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (we_i) begin
      if (addr_i == ADDR_LO_OFF) lo_q <= wdata_i;
      if (addr_i == ADDR_HI_OFF) hi_q <= wdata_i;
    end
  end

  assign lo_o    = lo_q;
  assign hi_o    = hi_q;
  assign match_o = (msg_addr_i == {hi_q, lo_q});
endmodule

// File: rtl/msi_vec_decode.sv
module msi_vec_decode #(
  parameter int NUM_GROUPS = 8,
  localparam int TOTAL = NUM_GROUPS * 32,
  localparam int VW = $clog2(TOTAL)
) (
  input  logic             hit_i,
  input  logic [31:0]      vec_i,
  output logic             in_range_o,
  output logic [TOTAL-1:0] set_o
);
  assign in_range_o = (vec_i < 32'(TOTAL));

  always_comb begin
    set_o = '0;
    if (hit_i && in_range_o) set_o[vec_i[VW-1:0]] = 1'b1;
  end
endmodule

// File: rtl/msi_vec_group.sv
module msi_vec_group
  import msi_pkg::*;
#(
  parameter int G_IDX = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic [GRP_W-1:0]  set_i,
  output logic [GRP_W-1:0]  en_o,
  output logic [GRP_W-1:0]  mask_o,
  output logic [GRP_W-1:0]  stat_o,
  output logic              pend_o
);
  localparam logic [REG_AW-1:0] ENA_OFF  = grp_reg_off(G_IDX, REG_ENA);
  localparam logic [REG_AW-1:0] MASK_OFF = grp_reg_off(G_IDX, REG_MASK);
  localparam logic [REG_AW-1:0] STAT_OFF = grp_reg_off(G_IDX, REG_STAT);

  logic [GRP_W-1:0] en_q, mask_q, stat_q, clr_w, latch_w;
  logic wr_en, wr_mask, wr_stat;

  assign wr_en   = we_i && (addr_i == ENA_OFF);
  assign wr_mask = we_i && (addr_i == MASK_OFF);
  assign wr_stat = we_i && (addr_i == STAT_OFF);
  assign clr_w   = wr_stat ? wdata_i : '0;
  assign latch_w = set_i & en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      mask_q <= '0;
      stat_q <= '0;
    end else begin
      if (wr_en)   en_q   <= wdata_i;
      if (wr_mask) mask_q <= wdata_i;
      // a new message outranks a same-cycle clear
      stat_q <= (stat_q & ~clr_w) | latch_w;
    end
  end

  assign en_o   = en_q;
  assign mask_o = mask_q;
  assign stat_o = stat_q;
  assign pend_o = |(stat_q & ~mask_q);

  assert_disabled_not_latched_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q & ~$past(stat_q) & ~$past(en_q)) == '0);

  assert_clear_needs_one_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(stat_q) & ~stat_q & ~$past(clr_w)) == '0);

  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q & $past(set_i & en_q)) == $past(set_i & en_q));
endmodule

// File: rtl/msi_vec_ctrl.sv
module msi_vec_ctrl
  import msi_pkg::*;
#(
  parameter int NUM_GROUPS = 8,
  localparam int TOTAL = NUM_GROUPS * GRP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              msg_valid_i,
  input  logic [63:0]       msg_addr_i,
  input  logic [31:0]       msg_data_i,
  output logic              irq_o
);
  logic [31:0]      addr_lo, addr_hi;
  logic             addr_match, hit, in_range;
  logic [TOTAL-1:0] set_all, stat_all;
  logic [GRP_W-1:0] en_w [NUM_GROUPS];
  logic [GRP_W-1:0] mask_w [NUM_GROUPS];
  logic [GRP_W-1:0] stat_w [NUM_GROUPS];
  logic [NUM_GROUPS-1:0] pend_w;
  logic irq_q;

  msi_addr_regs u_addr (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .msg_addr_i(msg_addr_i),
    .lo_o(addr_lo), .hi_o(addr_hi), .match_o(addr_match)
  );

  assign hit = msg_valid_i && addr_match;

  msi_vec_decode #(.NUM_GROUPS(NUM_GROUPS)) u_dec (
    .hit_i(hit), .vec_i(msg_data_i), .in_range_o(in_range), .set_o(set_all)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    msi_vec_group #(.G_IDX(g)) u_grp (
      .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
      .wdata_i(reg_wdata_i), .set_i(set_all[g*GRP_W +: GRP_W]),
      .en_o(en_w[g]), .mask_o(mask_w[g]), .stat_o(stat_w[g]), .pend_o(pend_w[g])
    );
    assign stat_all[g*GRP_W +: GRP_W] = stat_w[g];
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_LO_OFF) reg_rdata_o = addr_lo;
    if (reg_addr_i == ADDR_HI_OFF) reg_rdata_o = addr_hi;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (reg_addr_i == grp_reg_off(g, REG_ENA))  reg_rdata_o = en_w[g];
      if (reg_addr_i == grp_reg_off(g, REG_MASK)) reg_rdata_o = mask_w[g];
      if (reg_addr_i == grp_reg_off(g, REG_STAT)) reg_rdata_o = stat_w[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |pend_w;
  end
  assign irq_o = irq_q;

  assert_mismatch_no_effect_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_i && !addr_match && !reg_we_i) |=> $stable(stat_all));

  assert_out_of_range_dropped_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_i && addr_match && !in_range && !reg_we_i) |=> $stable(stat_all));

  assert_irq_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(stat_all) == '0) |-> !irq_o);
endmodule

// File: tb/sim_msi_vec_ctrl.sv
`timescale 1ns/1ps
module sim_msi_vec_ctrl;
  localparam int NG = 2;
  localparam int NV = NG * 32;
  localparam logic [63:0] MADDR = 64'h0000_0001_FEE0_0040;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0, msg_valid = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, rdata, msg_data = '0;
  logic [63:0] msg_addr = '0;
  logic irq;
  int checks = 0, fails = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  msi_vec_ctrl #(.NUM_GROUPS(NG)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(rdata), .msg_valid_i(msg_valid),
    .msg_addr_i(msg_addr), .msg_data_i(msg_data), .irq_o(irq)
  );

  function automatic logic [11:0] ena(int g);  return 12'(12'h828 + 12*g); endfunction
  function automatic logic [11:0] msk(int g);  return 12'(12'h82C + 12*g); endfunction
  function automatic logic [11:0] sts(int g);  return 12'(12'h830 + 12*g); endfunction

  task automatic tick; @(posedge clk); @(negedge clk); endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    reg_addr = a; #1; v = rdata;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string req);
    logic [31:0] v;
    rd(a, v);
    chk(v === exp, req, v, exp);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    tick;
    reg_we = 0;
  endtask

  task automatic msg(input logic [63:0] a, input logic [31:0] v);
    msg_valid = 1; msg_addr = a; msg_data = v;
    tick;
    msg_valid = 0;
  endtask

  task automatic irq_chk(input bit exp, input string req);
    chk(irq === exp, req, 32'(irq), 32'(exp));
  endtask

  initial begin : watchdog
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd_chk(12'h820, 0, "R1"); rd_chk(12'h824, 0, "R1");
    for (int g = 0; g < NG; g++) begin
      rd_chk(ena(g), 0, "R1"); rd_chk(msk(g), 0, "R1"); rd_chk(sts(g), 0, "R1");
    end
    irq_chk(0, "R1");

    // R2 address words
    wr(12'h820, MADDR[31:0]); wr(12'h824, MADDR[63:32]);
    rd_chk(12'h820, MADDR[31:0], "R2"); rd_chk(12'h824, MADDR[63:32], "R2");
    rd_chk(12'h81C, 0, "R2"); rd_chk(12'h900, 0, "R2");

    // R3 per-group registers at 12-byte stride
    for (int g = 0; g < NG; g++) begin
      wr(ena(g), 32'hA5A5_0000 + 32'(g)); wr(msk(g), 32'h3C3C_0000 + 32'(g));
    end
    for (int g = 0; g < NG; g++) begin
      rd_chk(ena(g), 32'hA5A5_0000 + 32'(g), "R3");
      rd_chk(msk(g), 32'h3C3C_0000 + 32'(g), "R3");
      rd_chk(sts(g), 0, "R8 enable/mask writes leave status");
    end

    // R4 / R10 / R8 sweep of every vector
    for (int g = 0; g < NG; g++) begin
      wr(ena(g), 32'hFFFF_FFFF); wr(msk(g), 0);
    end
    for (int v = 0; v < NV; v++) begin
      msg(MADDR, 32'(v));
      rd_chk(sts(v / 32), 32'(1) << (v % 32), "R4");
      rd_chk(sts(1 - v / 32), 0, "R4 other group");
      irq_chk(0, "R10 registered lag");
      tick;
      irq_chk(1, "R10");
      wr(sts(v / 32), 32'(1) << (v % 32));
      rd_chk(sts(v / 32), 0, "R8");
      tick;
      irq_chk(0, "R10 after clear");
    end

    // R5 sparse enable
    wr(ena(0), 32'h5555_5555); wr(ena(1), 32'h0F0F_0F0F);
    for (int v = 0; v < NV; v++) msg(MADDR, 32'(v));
    rd_chk(sts(0), 32'h5555_5555, "R5"); rd_chk(sts(1), 32'h0F0F_0F0F, "R5");
    wr(ena(0), 0);
    rd_chk(sts(0), 32'h5555_5555, "R5 disable keeps status");
    msg(MADDR, 32'd1);
    rd_chk(sts(0), 32'h5555_5555, "R5 disabled vector");

    // R8 partial and zero write
    wr(sts(0), 32'h0000_FFFF);
    rd_chk(sts(0), 32'h5555_0000, "R8 partial");
    wr(sts(0), 32'h0);
    rd_chk(sts(0), 32'h5555_0000, "R8 zero write");

    // R10 masks
    wr(msk(0), 32'hFFFF_0000); wr(msk(1), 32'hFFFF_FFFF);
    tick; irq_chk(0, "R10 all masked");
    wr(msk(1), 32'hFFFF_FFFE);
    irq_chk(0, "R10 lag");
    tick; irq_chk(1, "R10 unmasked");
    wr(sts(0), 32'hFFFF_FFFF); wr(sts(1), 32'hFFFF_FFFF);
    wr(msk(0), 0); wr(msk(1), 0);
    wr(ena(0), 32'hFFFF_FFFF); wr(ena(1), 32'hFFFF_FFFF);
    tick; irq_chk(0, "R10 cleared");

    // R6 address mismatch
    msg(MADDR ^ 64'h1, 32'd3);
    msg(MADDR ^ 64'h1_0000_0000, 32'd40);
    rd_chk(sts(0), 0, "R6"); rd_chk(sts(1), 0, "R6");

    // R7 out of range
    msg(MADDR, 32'(NV)); msg(MADDR, 32'd100); msg(MADDR, 32'hFFFF_FFFF);
    msg(MADDR, 32'(NV + 5));
    rd_chk(sts(0), 0, "R7"); rd_chk(sts(1), 0, "R7");
    tick; irq_chk(0, "R7");

    // R9 set wins over same-cycle clear
    msg(MADDR, 32'd7); msg(MADDR, 32'd8);
    rd_chk(sts(0), 32'h0000_0180, "R9 setup");
    reg_we = 1; reg_addr = sts(0); reg_wdata = 32'h0000_0180;
    msg_valid = 1; msg_addr = MADDR; msg_data = 32'd7;
    tick;
    reg_we = 0; msg_valid = 0;
    rd_chk(sts(0), 32'h0000_0080, "R9");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule